// File: doc/BRIEF.md
# Timer Interrupt and Output Router

This block sits beside a pair of countdown timers. It turns their events into interrupt requests and drives three output pins: a primary interrupt pin, a multi-function pin and a dedicated timer-1 pin. Each timer sends a one-cycle pulse when its output goes inactive, plus a flag that says the pulse came from software stopping the timer. A generic event input stands for every other interrupt source. The block latches qualified events into sticky status bits. Software clears those bits by writing ones to them.

Per-source enable bits decide which latched bits may raise a request. Per-timer routing bits send each timer's request to the primary pin or to the multi-function pin. The multi-function pin can instead show the timer-0 output level or an oscillator signal. Each pin has its own polarity bit and drive-type bit. Open-drain drive is modelled as a data/output-enable pair: the data is held at 0 and the output enable is raised only while the pin pulls low. A standby flag forces all three pins to open-drain drive, whatever their programmed drive type.

Software reaches four 8-bit registers through a single-cycle write strobe with a 2-bit address. Reads are combinational from the address.

Top module: `tir_router`

## Requirements
- R1: After reset all four registers read 0, and every pin gives data 0 with output enable 1. In that state a pin is active-high open-drain with its level at 0.
- R2: On a clock edge with `t0_evt` high and `t0_stop` low, status bit 1 becomes 1. The same holds for `t1_evt`/`t1_stop` and status bit 2, and for `gen_evt` and status bit 3. An event whose stop flag is high sets nothing.
- R3: A write to address 0 clears every status bit 3..1 whose write-data bit is 1. It leaves every bit whose write-data bit is 0 unchanged. If a set and a clear reach the same bit in one cycle, the bit ends up 1.
- R4: The enable register (address 1) gates the latched bits as requests: bit 6 for timer 0, bit 7 for timer 1 and bit 5 for the generic source. Status bits latch whatever the enables are.
- R5: The routing register (address 2) sends timer 0's request to the primary pin when its bit 3 is 0 and to the multi-function pin when it is 1. Bit 4 does the same for timer 1. The generic request always goes to the primary pin. A pin's level is 1 while any enabled request routed to it is pending.
- R6: The output-mode register (address 3) selects the multi-function pin's level with bits 7:6. 00 gives the requests routed to that pin, 01 gives `t0_lvl`, and 10 or 11 gives `osc_in`. The timer-1 pin's level is `t1_lvl`.
- R7: Each pin has a pair of output-mode bits: bits 1:0 for the timer-1 pin, 3:2 for the primary pin and 5:4 for the multi-function pin. In each pair the lower bit is polarity (0 active-high, 1 active-low) and the upper bit is drive type (1 push-pull, 0 open-drain). Let v be the pin's level XOR its polarity bit. With push-pull drive the pin gives data v and output enable 1. With open-drain drive it gives data 0 and output enable NOT v.
- R8: While `standby` is 1, all three pins follow the open-drain rule of R7 whatever their drive-type bits are. The programmed drive type returns once `standby` is 0.
- R9: Status bit 0 reads 1 exactly when an enabled request is pending at a pin. Such a request is routed to the primary pin, or routed to the multi-function pin while bits 7:6 of the output-mode register are 00.
- R10: The enable, routing and output-mode registers read back all 8 written bits. Status bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 routing, 3 output mode) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| t0_lvl | input | 1 | Timer 0 output level |
| t1_lvl | input | 1 | Timer 1 output level |
| t0_evt | input | 1 | Timer 0 went-inactive pulse |
| t1_evt | input | 1 | Timer 1 went-inactive pulse |
| t0_stop | input | 1 | Timer 0 event caused by software stop |
| t1_stop | input | 1 | Timer 1 event caused by software stop |
| gen_evt | input | 1 | Generic interrupt event pulse |
| osc_in | input | 1 | Oscillator signal |
| standby | input | 1 | Standby flag |
| irq_o | output | 1 | Primary interrupt pin data |
| irq_oe | output | 1 | Primary interrupt pin output enable |
| mfo_o | output | 1 | Multi-function pin data |
| mfo_oe | output | 1 | Multi-function pin output enable |
| t1p_o | output | 1 | Timer-1 pin data |
| t1p_oe | output | 1 | Timer-1 pin output enable |

## Verification
The hardest state to reach is one where several status bits are latched, each has a different enable, and each is routed to a different pin, all under one pin configuration. Each pin's level then comes from a three-way intersection of registers. To reach it, the stimulus clears the status, programs the enable and routing registers, and pulses a chosen set of events. It does this for every combination of three enables, two routing bits and three event bits, then predicts both pins and the summary bit from that arithmetic. A second sweep runs every polarity and drive pairing against the standby flag and the input levels. Directed cases then cover a set colliding with a clear in the same cycle and stop-flagged events.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int DW   = 8;
  localparam int AW   = 2;
  localparam int NSRC = 3;

  localparam logic [AW-1:0] A_STAT = 2'd0;
  localparam logic [AW-1:0] A_EN   = 2'd1;
  localparam logic [AW-1:0] A_RT   = 2'd2;
  localparam logic [AW-1:0] A_OM   = 2'd3;

  localparam int ST_SUM = 0;
  localparam int ST_LO  = 1;

  localparam int EN_GEN = 5;
  localparam int EN_T0  = 6;
  localparam int EN_T1  = 7;
  localparam int RT_T0  = 3;
  localparam int RT_T1  = 4;

  localparam int OM_T1P = 0;
  localparam int OM_IRQ = 2;
  localparam int OM_MFO = 4;
  localparam int OM_SEL = 6;

  typedef enum logic [1:0] {
    MF_REQ  = 2'b00,
    MF_T0   = 2'b01,
    MF_OSCA = 2'b10,
    MF_OSCB = 2'b11
  } mfo_sel_t;

  typedef struct packed {
    logic pp;
    logic pol;
  } pin_cfg_t;
endpackage

// File: rtl/tir_cfg.sv
module tir_cfg
  import tir_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] rt_q,
  output logic [DW-1:0] om_q,
  output logic          clr_we
);
  logic en_ce, rt_ce, om_ce;
  logic [DW-1:0] en_d, rt_d, om_d;

  always_comb begin
    en_ce  = wr && (addr == A_EN);
    rt_ce  = wr && (addr == A_RT);
    om_ce  = wr && (addr == A_OM);
    clr_we = wr && (addr == A_STAT);
    en_d   = en_ce ? wdata : en_q;
    rt_d   = rt_ce ? wdata : rt_q;
    om_d   = om_ce ? wdata : om_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      rt_q <= '0;
      om_q <= '0;
    end else begin
      en_q <= en_d;
      rt_q <= rt_d;
      om_q <= om_d;
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(en_q) && $stable(rt_q) && $stable(om_q)));
endmodule

// File: rtl/tir_status.sv
module tir_status
  import tir_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] stop,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] stat_q
);
  logic [NSRC-1:0] stat_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic set_i, clr_i;
    always_comb begin
      set_i     = evt[i] && !stop[i];
      clr_i     = clr_we && clr_mask[i];
      stat_d[i] = set_i || (stat_q[i] && !clr_i);
    end

    // R2
    set_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && !stop[i]) |=> stat_q[i]);
    // R2
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[i] && (!evt[i] || stop[i])) |=> !stat_q[i]);
    // R3
    clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[i] && !evt[i]) |=> !stat_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/tir_pad.sv
module tir_pad
  import tir_pkg::*;
(
  input  logic     lvl,
  input  pin_cfg_t cfg,
  input  logic     standby,
  output logic     pad_o,
  output logic     pad_oe
);
  logic v, push;

  always_comb begin
    v    = lvl ^ cfg.pol;
    push = cfg.pp && !standby;
    if (push) begin
      pad_o  = v;
      pad_oe = 1'b1;
    end else begin
      pad_o  = 1'b0;
      pad_oe = !v;
    end
  end
endmodule

// File: rtl/tir_router.sv
module tir_router
  import tir_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          t0_lvl,
  input  logic          t1_lvl,
  input  logic          t0_evt,
  input  logic          t1_evt,
  input  logic          t0_stop,
  input  logic          t1_stop,
  input  logic          gen_evt,
  input  logic          osc_in,
  input  logic          standby,
  output logic          irq_o,
  output logic          irq_oe,
  output logic          mfo_o,
  output logic          mfo_oe,
  output logic          t1p_o,
  output logic          t1p_oe
);
  localparam int NPIN = 3;
  localparam int PADW = DW - ST_LO - NSRC;

  logic [DW-1:0]   en_q, rt_q, om_q;
  logic            clr_we;
  logic [NSRC-1:0] stat_q, en_vec, to_mfo, act;
  logic            prim_req, mfo_req, summary, mfo_lvl;
  mfo_sel_t        msel;
  pin_cfg_t        cfg   [NPIN];
  logic [NPIN-1:0] lvl, po, poe;

  tir_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .rt_q(rt_q), .om_q(om_q), .clr_we(clr_we)
  );

  tir_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .evt({gen_evt, t1_evt, t0_evt}),
    .stop({1'b0, t1_stop, t0_stop}),
    .clr_we(clr_we),
    .clr_mask(reg_wdata[ST_LO +: NSRC]),
    .stat_q(stat_q)
  );

  always_comb begin
    en_vec   = {en_q[EN_GEN], en_q[EN_T1], en_q[EN_T0]};
    to_mfo   = {1'b0, rt_q[RT_T1], rt_q[RT_T0]};
    act      = stat_q & en_vec;
    prim_req = |(act & ~to_mfo);
    mfo_req  = |(act & to_mfo);
    msel     = mfo_sel_t'(om_q[OM_SEL +: 2]);
    case (msel)
      MF_REQ:  mfo_lvl = mfo_req;
      MF_T0:   mfo_lvl = t0_lvl;
      default: mfo_lvl = osc_in;
    endcase
    summary = prim_req || (mfo_req && (msel == MF_REQ));
    lvl     = {t1_lvl, mfo_lvl, prim_req};
    cfg[0]  = pin_cfg_t'(om_q[OM_IRQ +: 2]);
    cfg[1]  = pin_cfg_t'(om_q[OM_MFO +: 2]);
    cfg[2]  = pin_cfg_t'(om_q[OM_T1P +: 2]);
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pad
    tir_pad u_pad (
      .lvl(lvl[p]), .cfg(cfg[p]), .standby(standby),
      .pad_o(po[p]), .pad_oe(poe[p])
    );
  end

  assign irq_o  = po[0];
  assign irq_oe = poe[0];
  assign mfo_o  = po[1];
  assign mfo_oe = poe[1];
  assign t1p_o  = po[2];
  assign t1p_oe = poe[2];

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {{PADW{1'b0}}, stat_q, summary};
      A_EN:    reg_rdata = en_q;
      A_RT:    reg_rdata = rt_q;
      default: reg_rdata = om_q;
    endcase
  end

  // R8
  stby_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!irq_o && !mfo_o && !t1p_o));
  // R4
  no_en_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[EN_T0] == 1'b0 && en_q[EN_T1] == 1'b0 && en_q[EN_GEN] == 1'b0)
      |-> !summary);
  // R9
  sum_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (om_q[OM_IRQ +: 2] == 2'b10 && !standby && !irq_o && msel != MF_REQ)
      |-> !reg_rdata[ST_SUM] || reg_addr != A_STAT);
endmodule

// File: tb/tir_router_bench.sv
module tir_router_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic t0_lvl = 0, t1_lvl = 0, t0_evt = 0, t1_evt = 0, t0_stop = 0, t1_stop = 0;
  logic gen_evt = 0, osc_in = 0, standby = 0;
  logic irq_o, irq_oe, mfo_o, mfo_oe, t1p_o, t1p_oe;
  int nchk = 0, nfail = 0;

  always #(CLK_NS/2) clk = ~clk;

  tir_router u_tir_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .t0_lvl(t0_lvl), .t1_lvl(t1_lvl), .t0_evt(t0_evt), .t1_evt(t1_evt),
    .t0_stop(t0_stop), .t1_stop(t1_stop), .gen_evt(gen_evt),
    .osc_in(osc_in), .standby(standby),
    .irq_o(irq_o), .irq_oe(irq_oe), .mfo_o(mfo_o), .mfo_oe(mfo_oe),
    .t1p_o(t1p_o), .t1p_oe(t1p_oe)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [2:0] s, input logic [1:0] stp);
    @(negedge clk);
    t0_evt = s[0]; t1_evt = s[1]; gen_evt = s[2];
    t0_stop = stp[0]; t1_stop = stp[1];
    @(negedge clk);
    t0_evt = 0; t1_evt = 0; gen_evt = 0; t0_stop = 0; t1_stop = 0;
  endtask

  function automatic logic [1:0] pad(input logic l, input logic pol,
                                     input logic pp, input logic sb);
    logic v;
    v = l ^ pol;
    if (pp && !sb) return {v, 1'b1};
    return {1'b0, !v};
  endfunction

  initial begin
    #(CLK_NS * 190000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [2:0] act, m;
    logic [1:0] e;
    logic pr, mr, sb, l0, l1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); chk("R1 reg", d, 8'h00);
    end
    chk("R1 pins", {2'b0, irq_o, irq_oe, mfo_o, mfo_oe, t1p_o, t1p_oe}, 8'b00_010101);
    @(negedge clk); rst_n = 1'b1;

    // R10 readback
    wr(2'd1, 8'hA5); rd(2'd1, d); chk("R10 en", d, 8'hA5);
    wr(2'd2, 8'h5A); rd(2'd2, d); chk("R10 rt", d, 8'h5A);
    wr(2'd3, 8'hC3); rd(2'd3, d); chk("R10 om", d, 8'hC3);

    // Sweep R2 R4 R5 R9: mfo requests, push-pull active-high
    wr(2'd3, 8'b00_10_10_10);
    for (int en = 0; en < 8; en++)
      for (int rt = 0; rt < 4; rt++)
        for (int s = 0; s < 8; s++) begin
          wr(2'd0, 8'h0E);
          wr(2'd1, {en[1], en[0], en[2], 5'b0});
          wr(2'd2, {3'b0, rt[1], rt[0], 3'b0});
          pulse(s[2:0], 2'b00);
          act = s[2:0] & en[2:0];
          pr  = |(act & ~{1'b0, rt[1:0]});
          mr  = |(act & {1'b0, rt[1:0]});
          #1;
          chk("R5 irq pin", {6'b0, irq_o, irq_oe}, {6'b0, pr, 1'b1});
          chk("R6 mfo req", {6'b0, mfo_o, mfo_oe}, {6'b0, mr, 1'b1});
          rd(2'd0, d);
          chk("R9 R2 status", d, {4'b0, s[2:0], pr | mr});
        end

    // R9: mfo not in request mode hides its requests from the summary
    wr(2'd0, 8'h0E); wr(2'd1, 8'h40); wr(2'd2, 8'h08); wr(2'd3, 8'b01_10_10_10);
    pulse(3'b001, 2'b00);
    rd(2'd0, d); chk("R9 hidden", d, 8'h02);

    // R2 stop flags suppress
    wr(2'd0, 8'h0E);
    pulse(3'b011, 2'b11);
    rd(2'd0, d); chk("R2 stop", d, 8'h00);
    pulse(3'b011, 2'b01);
    rd(2'd0, d); chk("R2 stop t0 only", d, 8'h04);

    // R3 write-0 no effect, selective clear, set beats clear
    wr(2'd1, 8'h00);
    pulse(3'b111, 2'b00);
    wr(2'd0, 8'h00); rd(2'd0, d); chk("R3 write0", d, 8'h0E);
    wr(2'd0, 8'h04); rd(2'd0, d); chk("R3 clear t1", d, 8'h0A);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h0E; t0_evt = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0; t0_evt = 0;
    rd(2'd0, d); chk("R3 set wins", d, 8'h02);
    wr(2'd0, 8'h0E);

    // Sweep R6 R7 R8: every polarity/drive pairing; irq level 0
    for (int mm = 0; mm < 64; mm++) begin
      m = 3'b0;
      for (int sel = 0; sel < 3; sel++) begin
        wr(2'd3, {(sel == 0) ? 2'b01 : 2'b10, mm[5:0]});
        for (int k = 0; k < 8; k++) begin
          sb = k[0]; l0 = k[1]; l1 = k[2];
          standby = sb; t0_lvl = l0; t1_lvl = l1; osc_in = l0 ^ l1;
          #1;
          e = pad(1'b0, mm[2], mm[3], sb);
          chk("R7 R8 irq", {6'b0, irq_o, irq_oe}, {6'b0, e});
          e = pad((sel == 0) ? l0 : (l0 ^ l1), mm[4], mm[5], sb);
          chk("R6 R8 mfo", {6'b0, mfo_o, mfo_oe}, {6'b0, e});
          e = pad(l1, mm[0], mm[1], sb);
          chk("R7 R8 t1p", {6'b0, t1p_o, t1p_oe}, {6'b0, e});
        end
        if (sel == 2) m = 3'b1;
      end
    end
    standby = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule